// File: doc/BRIEF.md
# Redirection Pin Service Scanner

This block sits in an I/O interrupt controller. It holds one 64-bit redirection entry for each input pin, keeps a request bit per pin, and walks the pins from the lowest index to the highest. For every pin that has a request pending and is not blocked, it emits one delivery request that carries vector, destination, destination mode, delivery mode and trigger mode. The delivery request uses a valid/ready handshake. Entries are loaded through a single-cycle write port. An end-of-interrupt input clears the remote-IRR state of level pins.

Delivery attributes normally come straight from the entry. When remapping is turned on, the block sends the entry and pin index to an external remap unit and uses the attributes that come back. A remap fault drops that interrupt and ends the pass at once. A pin whose delivery mode selects a legacy external controller gets its vector from an acknowledge handshake with that controller, not from the entry.

Top module: `redir_pin_scanner`

## Requirements
- R1: Within one pass, pins are visited in ascending index order. Exactly one delivery is issued for each serviceable pin, meaning a pin whose request bit is set, whose mask bit is clear, and whose remote-IRR bit is clear.
- R2: A pin whose entry has the mask bit (bit 16) set is not serviced. Its request stays pending and is delivered once the mask is cleared.
- R3: With remap enabled, the block raises a remap request carrying the pin index and the full entry. Vector, destination, destination mode, delivery mode and trigger mode are then taken from the remap response.
- R4: A remap response flagged as a fault drops that interrupt and clears its request if the entry is edge-triggered. It also ends the pass at once, so the next pass starts again from pin 0.
- R5: With remap disabled, the fields are decoded from the entry as follows: vector bits 7:0, delivery mode bits 10:8, destination mode bit 11, trigger bit 15 (1 = level), destination bits 63:56.
- R6: An edge-triggered pin's request is set by a rising edge on its input. The request is cleared when its delivery is accepted, and the pin is not delivered again without a new edge.
- R7: A level-triggered pin's request follows its input. Remote IRR (entry bit 14) is set when the delivery is accepted. The pin is not delivered again until an EOI whose vector equals the entry vector clears remote IRR, and an EOI with any other vector leaves it set.
- R8: Delivery mode 3'b111 raises a legacy-controller acknowledge request. The vector it returns replaces the entry vector in the delivery.
- R9: The polarity bit (bit 13) and delivery-status bit (bit 12) of an entry have no effect on the delivery.
- R10: While the delivery valid is high and ready is low, valid and all delivery fields hold steady.
- R11: After reset no request is raised on any output, and every entry is masked.
- R12: A scan starts whenever the block is idle and at least one pin is serviceable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Pin index of the entry to write |
| wr_data | input | 64 | Entry write data (bit 14 ignored) |
| pin_in | input | NUM_PINS | Interrupt input lines, active high |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| remap_en | input | 1 | Route entries through the remap unit |
| remap_req | output | 1 | Remap lookup request |
| remap_pin | output | IDX_W | Pin being looked up |
| remap_entry | output | 64 | Entry being looked up |
| remap_rsp_valid | input | 1 | Remap response strobe |
| remap_fault | input | 1 | Remap lookup failed |
| remap_vector | input | 8 | Remapped vector |
| remap_dest | input | 8 | Remapped destination |
| remap_dest_mode | input | 1 | Remapped destination mode |
| remap_dlv_mode | input | 3 | Remapped delivery mode |
| remap_trig | input | 1 | Remapped trigger mode |
| pic_ack_req | output | 1 | Legacy controller acknowledge request |
| pic_ack_valid | input | 1 | Legacy controller vector valid |
| pic_vector | input | 8 | Vector from legacy controller |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery accepted |
| dlv_vector | output | 8 | Delivery vector |
| dlv_dest | output | 8 | Delivery destination |
| dlv_dest_mode | output | 1 | Delivery destination mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_trig | output | 1 | Delivery trigger mode (1 = level) |

## Verification
All 24 pins are programmed with arithmetically distinct fields and raised in the same cycle. This sweep tells apart a correct ascending walk from one that reorders or repeats pins, and it catches field decode errors on every pin. Single-pin patterns then separate the masked, level, external-controller and polarity cases, where the only visible effect is whether a delivery appears and what it carries. Remap traffic is checked with a pin raised while a faulting lookup is still outstanding. That request must be served before a higher pending pin, which shows whether the pass was really cut short. A stalled ready line shows whether the delivery request holds steady.

// File: rtl/rps_pkg.sv
package rps_pkg;
  localparam int ENT_W  = 64;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DLV_W  = 3;

  // bit positions inside a redirection entry
  localparam int F_VEC_LO  = 0;
  localparam int F_DLV_LO  = 8;
  localparam int F_DMODE   = 11;
  localparam int F_RIRR    = 14;
  localparam int F_TRIG    = 15;
  localparam int F_MASK    = 16;
  localparam int F_DEST_LO = 56;

  localparam logic [DLV_W-1:0] DLV_EXTINT = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_REMAP = 3'd2,
    ST_PIC   = 3'd3,
    ST_SEND  = 3'd4
  } scan_state_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [DEST_W-1:0] dest;
    logic              dest_mode;
    logic [DLV_W-1:0]  dlv_mode;
    logic              trig;
  } dlv_attr_t;

  function automatic dlv_attr_t decode_entry(input logic [ENT_W-1:0] e);
    dlv_attr_t a;
    a.vector    = e[F_VEC_LO +: VEC_W];
    a.dest      = e[F_DEST_LO +: DEST_W];
    a.dest_mode = e[F_DMODE];
    a.dlv_mode  = e[F_DLV_LO +: DLV_W];
    a.trig      = e[F_TRIG];
    return a;
  endfunction
endpackage

// File: rtl/rps_entry_bank.sv
module rps_entry_bank
  import rps_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [ENT_W-1:0]                   wr_data,
  input  logic                               eoi_valid,
  input  logic [VEC_W-1:0]                   eoi_vector,
  input  logic [NUM_PINS-1:0]                rirr_set,
  output logic [NUM_PINS-1:0][ENT_W-1:0]     entry_o,
  output logic [NUM_PINS-1:0]                mask_o,
  output logic [NUM_PINS-1:0]                rirr_o,
  output logic [NUM_PINS-1:0]                trig_o
);
  localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << F_MASK;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [ENT_W-1:0] ent_q, ent_d;
    logic             wr_hit, eoi_hit, ent_en;

    assign wr_hit  = wr_en && (wr_idx == IDX_W'(i));
    assign eoi_hit = eoi_valid && (ent_q[F_VEC_LO +: VEC_W] == eoi_vector);
    assign ent_en  = wr_hit | eoi_hit | rirr_set[i];

    always_comb begin
      ent_d = ent_q;
      if (wr_hit) ent_d = wr_data;
      // remote IRR is owned by the block, never by the write port
      ent_d[F_RIRR] = ent_q[F_RIRR];
      if (eoi_hit)     ent_d[F_RIRR] = 1'b0;
      if (rirr_set[i]) ent_d[F_RIRR] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= ENT_RST;
      else if (ent_en) ent_q <= ent_d;
    end

    assign entry_o[i] = ent_q;
    assign mask_o[i]  = ent_q[F_MASK];
    assign rirr_o[i]  = ent_q[F_RIRR];
    assign trig_o[i]  = ent_q[F_TRIG];
  end
endmodule

// File: rtl/rps_req_tracker.sv
module rps_req_tracker #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] lvl_mode,
  input  logic [NUM_PINS-1:0] req_clr,
  output logic [NUM_PINS-1:0] req_o
);
  logic [NUM_PINS-1:0] pin_q, irr_q, irr_d, rise;

  assign rise = pin_in & ~pin_q;

  // level pins follow the line; edge pins latch a rising edge until serviced
  always_comb begin
    irr_d = (lvl_mode & pin_in) | (~lvl_mode & ((irr_q & ~req_clr) | rise));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
      irr_q <= '0;
    end else begin
      pin_q <= pin_in;
      irr_q <= irr_d;
    end
  end

  assign req_o = irr_q;
endmodule

// File: rtl/rps_scan_ctrl.sv
module rps_scan_ctrl
  import rps_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PINS-1:0]            svc,
  input  logic [NUM_PINS-1:0][ENT_W-1:0] entries,
  input  logic                           remap_en,
  input  logic                           remap_rsp_valid,
  input  logic                           remap_fault,
  input  dlv_attr_t                      remap_attr,
  input  logic                           pic_ack_valid,
  input  logic [VEC_W-1:0]               pic_vector,
  input  logic                           dlv_ready,
  output scan_state_e                    state_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [ENT_W-1:0]               cur_entry_o,
  output dlv_attr_t                      attr_o,
  output logic [NUM_PINS-1:0]            req_clr,
  output logic [NUM_PINS-1:0]            rirr_set
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);

  scan_state_e         state_q, state_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  dlv_attr_t           attr_q, attr_d, decoded;
  logic [NUM_PINS-1:0] pin_sel;
  logic [ENT_W-1:0]    cur_entry;
  logic                hit, last, attr_en, idx_en;

  assign pin_sel   = NUM_PINS'(1) << idx_q;
  assign hit       = |(svc & pin_sel);
  assign cur_entry = entries[idx_q];
  assign last      = (idx_q == LAST_IDX);
  assign decoded   = decode_entry(cur_entry);

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    attr_d   = attr_q;
    req_clr  = '0;
    rirr_set = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (|svc) begin
          state_d = ST_CHECK;
          idx_d   = '0;
        end
      end
      ST_CHECK: begin
        if (hit) begin
          if (remap_en) begin
            state_d = ST_REMAP;
          end else begin
            attr_d  = decoded;
            state_d = (decoded.dlv_mode == DLV_EXTINT) ? ST_PIC : ST_SEND;
          end
        end else if (last) begin
          state_d = ST_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_REMAP: begin
        if (remap_rsp_valid) begin
          if (remap_fault) begin
            if (!cur_entry[F_TRIG]) req_clr = pin_sel;
            state_d = ST_IDLE;
          end else begin
            attr_d  = remap_attr;
            state_d = (remap_attr.dlv_mode == DLV_EXTINT) ? ST_PIC : ST_SEND;
          end
        end
      end
      ST_PIC: begin
        if (pic_ack_valid) begin
          attr_d.vector = pic_vector;
          state_d       = ST_SEND;
        end
      end
      ST_SEND: begin
        if (dlv_ready) begin
          if (attr_q.trig) rirr_set = pin_sel;
          else             req_clr  = pin_sel;
          if (last) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_CHECK;
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign attr_en = (state_q == ST_CHECK && hit && !remap_en) ||
                   (state_q == ST_REMAP && remap_rsp_valid) ||
                   (state_q == ST_PIC && pic_ack_valid);
  assign idx_en  = (state_q == ST_IDLE) || (state_q == ST_CHECK) || (state_q == ST_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      attr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en)  idx_q  <= idx_d;
      if (attr_en) attr_q <= attr_d;
    end
  end

  assign state_o     = state_q;
  assign idx_o       = idx_q;
  assign cur_entry_o = cur_entry;
  assign attr_o      = attr_q;
endmodule

// File: rtl/redir_pin_scanner.sv
module redir_pin_scanner
  import rps_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [63:0]         wr_data,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  input  logic                remap_en,
  output logic                remap_req,
  output logic [IDX_W-1:0]    remap_pin,
  output logic [63:0]         remap_entry,
  input  logic                remap_rsp_valid,
  input  logic                remap_fault,
  input  logic [7:0]          remap_vector,
  input  logic [7:0]          remap_dest,
  input  logic                remap_dest_mode,
  input  logic [2:0]          remap_dlv_mode,
  input  logic                remap_trig,
  output logic                pic_ack_req,
  input  logic                pic_ack_valid,
  input  logic [7:0]          pic_vector,
  output logic                dlv_valid,
  input  logic                dlv_ready,
  output logic [7:0]          dlv_vector,
  output logic [7:0]          dlv_dest,
  output logic                dlv_dest_mode,
  output logic [2:0]          dlv_mode,
  output logic                dlv_trig
);
  logic [NUM_PINS-1:0][ENT_W-1:0] entries;
  logic [NUM_PINS-1:0] mask_vec, rirr_vec, trig_vec, req_vec, svc_vec;
  logic [NUM_PINS-1:0] req_clr, rirr_set;
  scan_state_e         scan_state;
  logic [IDX_W-1:0]    scan_idx;
  logic [ENT_W-1:0]    cur_entry;
  dlv_attr_t           remap_attr, attr;

  assign remap_attr = '{vector: remap_vector, dest: remap_dest, dest_mode: remap_dest_mode,
                        dlv_mode: remap_dlv_mode, trig: remap_trig};

  rps_entry_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .rirr_set(rirr_set),
    .entry_o(entries), .mask_o(mask_vec), .rirr_o(rirr_vec), .trig_o(trig_vec)
  );

  rps_req_tracker #(.NUM_PINS(NUM_PINS)) u_req (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvl_mode(trig_vec),
    .req_clr(req_clr), .req_o(req_vec)
  );

  assign svc_vec = req_vec & ~mask_vec & ~rirr_vec;

  rps_scan_ctrl #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .svc(svc_vec), .entries(entries),
    .remap_en(remap_en), .remap_rsp_valid(remap_rsp_valid), .remap_fault(remap_fault),
    .remap_attr(remap_attr), .pic_ack_valid(pic_ack_valid), .pic_vector(pic_vector),
    .dlv_ready(dlv_ready), .state_o(scan_state), .idx_o(scan_idx),
    .cur_entry_o(cur_entry), .attr_o(attr), .req_clr(req_clr), .rirr_set(rirr_set)
  );

  assign remap_req     = (scan_state == ST_REMAP);
  assign remap_pin     = scan_idx;
  assign remap_entry   = cur_entry;
  assign pic_ack_req   = (scan_state == ST_PIC);
  assign dlv_valid     = (scan_state == ST_SEND);
  assign dlv_vector    = attr.vector;
  assign dlv_dest      = attr.dest;
  assign dlv_dest_mode = attr.dest_mode;
  assign dlv_mode      = attr.dlv_mode;
  assign dlv_trig      = attr.trig;
endmodule

// File: rtl/rps_scan_checker.sv
module rps_scan_checker #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                remap_req,
  input logic [IDX_W-1:0]    remap_pin,
  input logic                remap_rsp_valid,
  input logic                remap_fault,
  input logic                pic_ack_req,
  input logic                dlv_valid,
  input logic                dlv_ready,
  input logic [7:0]          dlv_vector,
  input logic [7:0]          dlv_dest,
  input logic                dlv_dest_mode,
  input logic [2:0]          dlv_mode,
  input logic                dlv_trig,
  input logic [NUM_PINS-1:0] mask_vec,
  input logic [NUM_PINS-1:0] rirr_vec,
  input logic [IDX_W-1:0]    scan_idx
);
  // R10: a stalled delivery keeps its request and contents
  p_dlv_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid &&
      $stable({dlv_vector, dlv_dest, dlv_dest_mode, dlv_mode, dlv_trig}));

  // R4: a faulting lookup ends the pass with nothing else outstanding
  p_fault_ends_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    remap_req && remap_rsp_valid && remap_fault |=> !remap_req && !pic_ack_req && !dlv_valid);

  // R7: an accepted level delivery leaves remote IRR set for that pin
  p_level_sets_rirr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_ready && dlv_trig |=> rirr_vec[$past(scan_idx)]);

  // R8: a delivery that followed an acknowledge cycle is external-controller mode
  p_pic_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && $past(pic_ack_req) |-> dlv_mode == 3'b111);

  // R2: a lookup is never started for a masked pin
  p_remap_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remap_req) && !$past(wr_en) |-> !mask_vec[remap_pin]);
endmodule

bind redir_pin_scanner rps_scan_checker #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .remap_req(remap_req), .remap_pin(remap_pin),
  .remap_rsp_valid(remap_rsp_valid), .remap_fault(remap_fault), .pic_ack_req(pic_ack_req),
  .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
  .dlv_dest_mode(dlv_dest_mode), .dlv_mode(dlv_mode), .dlv_trig(dlv_trig),
  .mask_vec(mask_vec), .rirr_vec(rirr_vec), .scan_idx(scan_idx)
);

// File: tb/redir_pin_scanner_tb_top.sv
module redir_pin_scanner_tb_top;
  localparam int NP = 24;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [IW-1:0] wr_idx;
  logic [63:0] wr_data;
  logic [NP-1:0] pin_in;
  logic eoi_valid;
  logic [7:0] eoi_vector;
  logic remap_en;
  logic remap_req;
  logic [IW-1:0] remap_pin;
  logic [63:0] remap_entry;
  logic remap_rsp_valid, remap_fault, remap_dest_mode, remap_trig;
  logic [7:0] remap_vector, remap_dest;
  logic [2:0] remap_dlv_mode;
  logic pic_ack_req, pic_ack_valid;
  logic [7:0] pic_vector;
  logic dlv_valid, dlv_ready, dlv_dest_mode, dlv_trig;
  logic [7:0] dlv_vector, dlv_dest;
  logic [2:0] dlv_mode;

  always #10 clk = ~clk;  // 50 MHz

  redir_pin_scanner #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pin_in(pin_in), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .remap_en(remap_en),
    .remap_req(remap_req), .remap_pin(remap_pin), .remap_entry(remap_entry),
    .remap_rsp_valid(remap_rsp_valid), .remap_fault(remap_fault), .remap_vector(remap_vector),
    .remap_dest(remap_dest), .remap_dest_mode(remap_dest_mode), .remap_dlv_mode(remap_dlv_mode),
    .remap_trig(remap_trig), .pic_ack_req(pic_ack_req), .pic_ack_valid(pic_ack_valid),
    .pic_vector(pic_vector), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_vector(dlv_vector), .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode),
    .dlv_mode(dlv_mode), .dlv_trig(dlv_trig)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // delivery log
  logic [7:0] lg_vec [128];
  logic [7:0] lg_dest[128];
  logic       lg_dm  [128];
  logic [2:0] lg_mode[128];
  logic       lg_trig[128];
  int lg_n = 0;
  // remap lookup log
  int         rm_pin [32];
  logic [7:0] rm_evec[32];
  int rm_n = 0;
  int rsp_delay = 0;
  logic [NP-1:0] fault_mask = '0;
  int pic_n = 0;
  logic [7:0] pic_cfg = 8'h00;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dmod,
                                     input logic dmode, input logic trig, input logic msk,
                                     input logic [7:0] dest, input logic pol, input logic dst);
    logic [63:0] e;
    e = '0;
    e[7:0] = vec;  e[10:8] = dmod;  e[11] = dmode;  e[12] = dst;
    e[13] = pol;   e[15] = trig;    e[16] = msk;    e[63:56] = dest;
    return e;
  endfunction

  function automatic logic [7:0] sw_vec(input int p);  return 8'(8'h20 + p); endfunction
  function automatic logic [7:0] sw_dest(input int p); return 8'(p * 5 + 1); endfunction
  function automatic logic [2:0] sw_mode(input int p); return 3'(p % 4); endfunction
  function automatic logic       sw_dm(input int p);   return p[0]; endfunction

  // delivery monitor: samples after the bench has driven its negedge inputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (dlv_valid === 1'b1 && dlv_ready === 1'b1 && lg_n < 128) begin
        lg_vec[lg_n] = dlv_vector;  lg_dest[lg_n] = dlv_dest;  lg_dm[lg_n] = dlv_dest_mode;
        lg_mode[lg_n] = dlv_mode;   lg_trig[lg_n] = dlv_trig;  lg_n++;
      end
    end
  end

  // remap unit model: attributes computed from the pin index
  initial begin
    remap_rsp_valid = 1'b0; remap_fault = 1'b0; remap_vector = '0; remap_dest = '0;
    remap_dest_mode = 1'b0; remap_dlv_mode = '0; remap_trig = 1'b0;
    forever begin
      @(negedge clk);
      if (remap_req === 1'b1) begin
        automatic int p = int'(remap_pin);
        if (rm_n < 32) begin rm_pin[rm_n] = p; rm_evec[rm_n] = remap_entry[7:0]; rm_n++; end
        repeat (rsp_delay) @(negedge clk);
        remap_fault     = fault_mask[p];
        remap_vector    = 8'(8'h80 + p);
        remap_dest      = 8'(8'hC0 ^ p);
        remap_dest_mode = p[0];
        remap_dlv_mode  = 3'b001;
        remap_trig      = 1'b0;
        remap_rsp_valid = 1'b1;
        @(negedge clk);
        remap_rsp_valid = 1'b0;
        remap_fault     = 1'b0;
      end
    end
  end

  // legacy controller model
  initial begin
    pic_ack_valid = 1'b0; pic_vector = '0;
    forever begin
      @(negedge clk);
      if (pic_ack_req === 1'b1 && !pic_ack_valid) begin
        pic_ack_valid = 1'b1; pic_vector = pic_cfg; pic_n++;
      end else begin
        pic_ack_valid = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  task automatic wr_entry(input int p, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(p); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_pins(input logic [NP-1:0] m);
    @(negedge clk);
    pin_in = pin_in | m;
    @(negedge clk);
    pin_in = pin_in & ~m;
  endtask

  task automatic pulse_eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic wait_log(input int target, input string tag);
    for (int k = 0; k < 400 && lg_n < target; k++) @(negedge clk);
    check({tag, " delivery count"}, 64'(lg_n), 64'(target));
  endtask

  task automatic expect_quiet(input int cycles, input string tag);
    int n0;
    n0 = lg_n;
    repeat (cycles) @(negedge clk);
    check({tag, " no delivery"}, 64'(lg_n), 64'(n0));
  endtask

  task automatic chk_log(input int k, input string tag, input logic [7:0] v, input logic [7:0] d,
                         input logic dm, input logic [2:0] md, input logic tr);
    check({tag, " vector"},    64'(lg_vec[k]),  64'(v));
    check({tag, " dest"},      64'(lg_dest[k]), 64'(d));
    check({tag, " dest_mode"}, 64'(lg_dm[k]),   64'(dm));
    check({tag, " dlv_mode"},  64'(lg_mode[k]), 64'(md));
    check({tag, " trig"},      64'(lg_trig[k]), 64'(tr));
  endtask

  initial begin
    int base;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; pin_in = '0;
    eoi_valid = 1'b0; eoi_vector = '0; remap_en = 1'b0; dlv_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: idle outputs after reset, and a raised pin stays silent (all entries masked)
    check("R11 dlv_valid after reset", 64'(dlv_valid), 64'(0));
    check("R11 remap_req after reset", 64'(remap_req), 64'(0));
    check("R11 pic_ack_req after reset", 64'(pic_ack_req), 64'(0));
    pulse_pins(NP'(1));
    expect_quiet(40, "R11 masked-at-reset pin 0");

    // R2 / R12: unmasking pin 0 releases its retained request and a scan starts
    wr_entry(0, mk(sw_vec(0), sw_mode(0), sw_dm(0), 1'b0, 1'b0, sw_dest(0), 1'b0, 1'b0));
    wait_log(1, "R2 R12 retained request after unmask");
    chk_log(0, "R2 pin0", sw_vec(0), sw_dest(0), sw_dm(0), sw_mode(0), 1'b0);

    // R1 / R5: all pins raised at once, delivered in ascending order with decoded fields
    for (int p = 1; p < NP; p++)
      wr_entry(p, mk(sw_vec(p), sw_mode(p), sw_dm(p), 1'b0, 1'b0, sw_dest(p), 1'b0, 1'b0));
    base = lg_n;
    pulse_pins('1);
    wait_log(base + NP, "R1 sweep");
    for (int p = 0; p < NP; p++)
      chk_log(base + p, $sformatf("R1 R5 sweep pin %0d", p), sw_vec(p), sw_dest(p),
              sw_dm(p), sw_mode(p), 1'b0);

    // R6: edge requests were cleared by service, so nothing repeats
    expect_quiet(60, "R6 edge no repeat");

    // R9: polarity and delivery-status bits do not change the delivery
    wr_entry(4, mk(8'h44, 3'd2, 1'b0, 1'b0, 1'b0, 8'h12, 1'b1, 1'b1));
    base = lg_n;
    pulse_pins(NP'(1) << 4);
    wait_log(base + 1, "R9 pin4");
    chk_log(base, "R9 pin4", 8'h44, 8'h12, 1'b0, 3'd2, 1'b0);

    // R2: masked pin stays silent, then delivers once unmasked
    wr_entry(6, mk(sw_vec(6), sw_mode(6), sw_dm(6), 1'b0, 1'b1, sw_dest(6), 1'b0, 1'b0));
    pulse_pins(NP'(1) << 6);
    expect_quiet(40, "R2 masked pin 6");
    base = lg_n;
    wr_entry(6, mk(sw_vec(6), sw_mode(6), sw_dm(6), 1'b0, 1'b0, sw_dest(6), 1'b0, 1'b0));
    wait_log(base + 1, "R2 unmasked pin 6");
    chk_log(base, "R2 pin6", sw_vec(6), sw_dest(6), sw_dm(6), sw_mode(6), 1'b0);

    // R7: level pin with remote IRR gating
    wr_entry(10, mk(8'h5A, 3'd0, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b0));
    base = lg_n;
    @(negedge clk); pin_in[10] = 1'b1;
    wait_log(base + 1, "R7 level first");
    chk_log(base, "R7 level", 8'h5A, 8'h3C, 1'b1, 3'd0, 1'b1);
    expect_quiet(40, "R7 held by remote IRR");
    pulse_eoi(8'h5B);
    expect_quiet(30, "R7 mismatched EOI");
    base = lg_n;
    pulse_eoi(8'h5A);
    wait_log(base + 1, "R7 after matching EOI");
    @(negedge clk); pin_in[10] = 1'b0;
    pulse_eoi(8'h5A);
    expect_quiet(40, "R7 line low after EOI");

    // R8: external-controller mode takes its vector from the acknowledge cycle
    pic_cfg = 8'hA7;
    wr_entry(12, mk(8'h33, 3'b111, 1'b1, 1'b0, 1'b0, 8'h77, 1'b0, 1'b0));
    base = lg_n;
    pulse_pins(NP'(1) << 12);
    wait_log(base + 1, "R8 extint");
    chk_log(base, "R8 pin12", 8'hA7, 8'h77, 1'b1, 3'b111, 1'b0);
    check("R8 acknowledge cycles", 64'(pic_n), 64'(1));

    // R10: delivery held while ready is low
    dlv_ready = 1'b0;
    base = lg_n;
    pulse_pins(NP'(1) << 13);
    for (int k = 0; k < 100 && dlv_valid !== 1'b1; k++) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R10 valid held", 64'(dlv_valid), 64'(1));
      check("R10 vector held", 64'(dlv_vector), 64'(sw_vec(13)));
      check("R10 dest held", 64'(dlv_dest), 64'(sw_dest(13)));
    end
    dlv_ready = 1'b1;
    wait_log(base + 1, "R10 released");

    // R3: attributes taken from the remap response
    remap_en = 1'b1;
    rsp_delay = 0;
    base = lg_n;
    pulse_pins(NP'(1) << 8);
    wait_log(base + 1, "R3 remap pin 8");
    check("R3 lookup pin", 64'(rm_pin[0]), 64'(8));
    check("R3 lookup entry vector", 64'(rm_evec[0]), 64'(sw_vec(8)));
    chk_log(base, "R3 pin8", 8'h88, 8'hC8, 1'b0, 3'b001, 1'b0);

    // R4: fault on pin 2 ends the pass; pin 1 raised meanwhile goes before pin 9
    rsp_delay = 6;
    fault_mask = NP'(1) << 2;
    base = lg_n;
    pulse_pins((NP'(1) << 2) | (NP'(1) << 9));
    for (int k = 0; k < 100 && rm_n < 2; k++) @(negedge clk);
    pulse_pins(NP'(1) << 1);
    for (int k = 0; k < 200 && rm_n < 4; k++) @(negedge clk);
    wait_log(base + 2, "R4 after fault");
    check("R4 first lookup", 64'(rm_pin[1]), 64'(2));
    check("R4 restart from low pin", 64'(rm_pin[2]), 64'(1));
    check("R4 then pending pin 9", 64'(rm_pin[3]), 64'(9));
    chk_log(base, "R4 pin1", 8'h81, 8'hC1, 1'b1, 3'b001, 1'b0);
    chk_log(base + 1, "R4 pin9", 8'h89, 8'hC9, 1'b1, 3'b001, 1'b0);
    expect_quiet(40, "R4 faulted pin 2 dropped");
    check("R4 no further lookups", 64'(rm_n), 64'(4));

    finish_run();
  end
endmodule